// File: doc/BRIEF.md
# Multicycle 32-bit Integer Processor Core

This block is a small 32-bit processor core that runs a fixed subset of the RV32I base integer instructions. It does not overlap instructions. A five-state controller carries each instruction through fetch, decode, execute, memory access and write-back, so every instruction takes five clock cycles whatever its kind. The core holds the program counter, the instruction register, the operand and result latches, an immediate generator, an ALU, a 32-entry register file and the controller.

The core has two memory ports. The instruction port is read-only and returns the word at `imem_addr_o` combinationally. The data port also reads combinationally and writes on the clock edge when `dmem_we_o` is high. Both memories live outside the core. The supported instructions are the nine register-register ALU operations, the eight immediate ALU operations, word load, word store and branch-if-equal. Any other encoding moves through the five states without changing any state except the program counter.

Top module: `mc_core`

## Requirements
- R1: `rst_ni` is an asynchronous active-low reset. While it is low, `imem_addr_o` reads 0 and `dmem_we_o` reads 0, including right after a reset applied in the middle of an instruction. After release, the first fetch is from address 0.
- R2: Every instruction takes exactly five cycles, stepping through fetch, decode, execute, memory and write-back in that order. `imem_addr_o` stays constant through all five cycles. For a non-branch instruction it becomes PC+4 after the write-back edge.
- R3: Opcode 0110011 selects the register ops, with rd=[11:7], rs1=[19:15] and rs2=[24:20]. funct3 selects the op: 000 ADD, or SUB when bit 30 is 1; 001 SLL; 010 SLT; 100 XOR; 101 SRL, or SRA when bit 30 is 1; 110 OR; 111 AND.
- R4: Opcode 0010011 selects the immediate ops, with the same funct3 map and a sign-extended immediate taken from [31:20]. Bit 30 selects SRAI only when funct3 is 101. For SLLI, SRLI and SRAI the shift amount is [24:20].
- R5: SLT and SLTI compare as signed numbers and return 1 or 0. SRA and SRAI fill with the sign bit. Every shift uses only the low 5 bits of its amount.
- R6: LW is opcode 0000011 with funct3 010. SW is opcode 0100011 with funct3 010, and its immediate is {[31:25],[11:7]}. Both access a 32-bit word at rs1 plus the sign-extended 12-bit offset, and negative offsets are allowed.
- R7: BEQ is opcode 1100011 with funct3 000 and offset {[31],[7],[30:25],[11:8],0}. It is resolved in the execute cycle. If rs1 equals rs2, the PC becomes PC plus the offset; otherwise it becomes PC+4. That new value is on `imem_addr_o` from the edge that ends execute.
- R8: Register x0 always reads as zero. ALU results and loads that name x0 as the destination have no effect.
- R9: `dmem_we_o` is high for exactly one cycle per SW, in that SW's memory state, and at no other time.
- R10: An unsupported opcode, or funct3 011 with an ALU opcode, writes no register and no memory, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 32 | Instruction fetch byte address (the PC) |
| imem_rdata_i | input | 32 | Instruction word at `imem_addr_o` |
| dmem_addr_o | output | 32 | Data word byte address |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store strobe, one cycle per SW |
| dmem_rdata_i | input | 32 | Load data at `dmem_addr_o` |

## Verification
A controller that skips or repeats a state shows up on `imem_addr_o` within one instruction, because the five-cycle hold and the +4 step drift away from the expected cycle. A wrong ALU selection, immediate layout or register index shows up only later, when a store writes the wrong word to data memory. That is at most two instructions after the fault. A wrong branch decision changes the fetch address on the very edge that ends the execute cycle, so the bench checks the address at that exact cycle as well as the stored result. Stray write strobes are counted over each whole program, so an extra pulse in any state is seen.

// File: rtl/mc_core_pkg.sv
package mc_core_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RIDX = $clog2(NREG);

  localparam logic [6:0] OPC_REG  = 7'b0110011;
  localparam logic [6:0] OPC_IMM  = 7'b0010011;
  localparam logic [6:0] OPC_LOAD = 7'b0000011;
  localparam logic [6:0] OPC_STOR = 7'b0100011;
  localparam logic [6:0] OPC_BRCH = 7'b1100011;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB
  } state_e;

  typedef enum logic [3:0] {
    AO_ADD, AO_SUB, AO_AND, AO_OR, AO_XOR, AO_SLT, AO_SLL, AO_SRL, AO_SRA
  } aluop_e;

  typedef enum logic [2:0] {
    IK_NONE, IK_ALU_R, IK_ALU_I, IK_LOAD, IK_STORE, IK_BRANCH
  } ikind_e;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_core_pkg::*;
#(
  parameter int W = XLEN
) (
  input  aluop_e       op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  localparam int SHW = $clog2(W);

  logic [SHW-1:0] sh;
  assign sh = b_i[SHW-1:0];

  always_comb begin
    unique case (op_i)
      AO_ADD:  y_o = a_i + b_i;
      AO_SUB:  y_o = a_i - b_i;
      AO_AND:  y_o = a_i & b_i;
      AO_OR:   y_o = a_i | b_i;
      AO_XOR:  y_o = a_i ^ b_i;
      AO_SLT:  y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      AO_SLL:  y_o = a_i << sh;
      AO_SRL:  y_o = a_i >> sh;
      AO_SRA:  y_o = W'($signed(a_i) >>> sh);
      default: y_o = '0;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_core_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREG
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [$clog2(N)-1:0] waddr_i,
  input  logic [W-1:0]         wdata_i,
  input  logic [$clog2(N)-1:0] raddr_a_i,
  input  logic [$clog2(N)-1:0] raddr_b_i,
  output logic [W-1:0]         rdata_a_o,
  output logic [W-1:0]         rdata_b_o
);
  localparam int AW = $clog2(N);

  // entry 0 is not stored: it is the constant zero register
  logic [W-1:0] mem_q [1:N-1];

  for (genvar g = 1; g < N; g++) begin : g_row
    logic row_en;
    assign row_en = we_i && (waddr_i == AW'(g));
    always_ff @(posedge clk_i) begin
      if (row_en) mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_a_o = '0;
    rdata_b_o = '0;
    for (int k = 1; k < N; k++) begin
      if (raddr_a_i == AW'(k)) rdata_a_o = mem_q[k];
      if (raddr_b_i == AW'(k)) rdata_b_o = mem_q[k];
    end
  end
endmodule

// File: rtl/mc_immgen.sv
module mc_immgen
  import mc_core_pkg::*;
(
  input  logic [31:0] instr_i,
  input  ikind_e      kind_i,
  output logic [31:0] imm_o
);
  always_comb begin
    unique case (kind_i)
      IK_ALU_I, IK_LOAD:
        imm_o = {{20{instr_i[31]}}, instr_i[31:20]};
      IK_STORE:
        imm_o = {{20{instr_i[31]}}, instr_i[31:25], instr_i[11:7]};
      IK_BRANCH:
        imm_o = {{19{instr_i[31]}}, instr_i[31], instr_i[7],
                 instr_i[30:25], instr_i[11:8], 1'b0};
      default:
        imm_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_core_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] instr_i,
  input  logic        zero_i,
  output state_e      state_o,
  output ikind_e      kind_o,
  output aluop_e      alu_op_o,
  output logic        use_imm_o,
  output logic        ir_en_o,
  output logic        opr_en_o,
  output logic        res_en_o,
  output logic        mdr_en_o,
  output logic        rf_we_o,
  output logic        dmem_we_o,
  output logic        pc_we_o,
  output logic        br_take_o
);
  state_e      state_q, state_d;
  logic [6:0]  opc;
  logic [2:0]  f3;
  logic        alt;

  assign opc = instr_i[6:0];
  assign f3  = instr_i[14:12];
  assign alt = instr_i[30];

  // next-state process
  always_comb begin
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC:   state_d = ST_MEM;
      ST_MEM:    state_d = ST_WB;
      default:   state_d = ST_FETCH;
    endcase
  end

  // state register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  // instruction class
  always_comb begin
    kind_o = IK_NONE;
    unique case (opc)
      OPC_REG:  if (f3 != 3'b011) kind_o = IK_ALU_R;
      OPC_IMM:  if (f3 != 3'b011) kind_o = IK_ALU_I;
      OPC_LOAD: if (f3 == 3'b010) kind_o = IK_LOAD;
      OPC_STOR: if (f3 == 3'b010) kind_o = IK_STORE;
      OPC_BRCH: if (f3 == 3'b000) kind_o = IK_BRANCH;
      default:  kind_o = IK_NONE;
    endcase
  end

  // ALU operation select
  always_comb begin
    alu_op_o = AO_ADD;
    if (kind_o == IK_BRANCH) begin
      alu_op_o = AO_SUB;
    end else if (kind_o == IK_ALU_R || kind_o == IK_ALU_I) begin
      unique case (f3)
        3'b000:  alu_op_o = (kind_o == IK_ALU_R && alt) ? AO_SUB : AO_ADD;
        3'b001:  alu_op_o = AO_SLL;
        3'b010:  alu_op_o = AO_SLT;
        3'b100:  alu_op_o = AO_XOR;
        3'b101:  alu_op_o = alt ? AO_SRA : AO_SRL;
        3'b110:  alu_op_o = AO_OR;
        3'b111:  alu_op_o = AO_AND;
        default: alu_op_o = AO_ADD;
      endcase
    end
  end

  assign use_imm_o = (kind_o == IK_ALU_I) || (kind_o == IK_LOAD) ||
                     (kind_o == IK_STORE);

  // per-state clock enables
  assign ir_en_o   = (state_q == ST_FETCH);
  assign opr_en_o  = (state_q == ST_DECODE);
  assign res_en_o  = (state_q == ST_EXEC);
  assign mdr_en_o  = (state_q == ST_MEM) && (kind_o == IK_LOAD);
  assign dmem_we_o = (state_q == ST_MEM) && (kind_o == IK_STORE);
  assign rf_we_o   = (state_q == ST_WB) &&
                     ((kind_o == IK_ALU_R) || (kind_o == IK_ALU_I) ||
                      (kind_o == IK_LOAD));
  assign pc_we_o   = ((state_q == ST_EXEC) && (kind_o == IK_BRANCH)) ||
                     ((state_q == ST_WB) && (kind_o != IK_BRANCH));
  assign br_take_o = (state_q == ST_EXEC) && (kind_o == IK_BRANCH) && zero_i;

  assign state_o = state_q;
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_core_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [31:0] imem_addr_o,
  input  logic [31:0] imem_rdata_i,
  output logic [31:0] dmem_addr_o,
  output logic [31:0] dmem_wdata_o,
  output logic        dmem_we_o,
  input  logic [31:0] dmem_rdata_i
);
  state_e            state_q;
  ikind_e            kind;
  aluop_e            alu_op;
  logic              use_imm, ir_en, opr_en, res_en, mdr_en;
  logic              rf_we, pc_we, br_take, zero;
  logic [XLEN-1:0]   pc_q, pc_d;
  logic [31:0]       ir_q;
  logic [XLEN-1:0]   rs1_q, rs2_q, imm_q, res_q, mdr_q;
  logic [XLEN-1:0]   rs1_rd, rs2_rd, imm_w, alu_b, alu_y, wb_data;

  mc_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .instr_i   (ir_q),
    .zero_i    (zero),
    .state_o   (state_q),
    .kind_o    (kind),
    .alu_op_o  (alu_op),
    .use_imm_o (use_imm),
    .ir_en_o   (ir_en),
    .opr_en_o  (opr_en),
    .res_en_o  (res_en),
    .mdr_en_o  (mdr_en),
    .rf_we_o   (rf_we),
    .dmem_we_o (dmem_we_o),
    .pc_we_o   (pc_we),
    .br_take_o (br_take)
  );

  // program counter and instruction register carry reset
  assign pc_d = br_take ? (pc_q + imm_q) : (pc_q + XLEN'(4));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (pc_we) pc_q <= pc_d;
      if (ir_en) ir_q <= imem_rdata_i;
    end
  end

  mc_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk_i     (clk_i),
    .we_i      (rf_we),
    .waddr_i   (ir_q[7+RIDX-1:7]),
    .wdata_i   (wb_data),
    .raddr_a_i (ir_q[15+RIDX-1:15]),
    .raddr_b_i (ir_q[20+RIDX-1:20]),
    .rdata_a_o (rs1_rd),
    .rdata_b_o (rs2_rd)
  );

  mc_immgen u_imm (
    .instr_i (ir_q),
    .kind_i  (kind),
    .imm_o   (imm_w)
  );

  // datapath latches: enabled per state, no reset needed
  always_ff @(posedge clk_i) begin
    if (opr_en) begin
      rs1_q <= rs1_rd;
      rs2_q <= rs2_rd;
      imm_q <= imm_w;
    end
    if (res_en) res_q <= alu_y;
    if (mdr_en) mdr_q <= dmem_rdata_i;
  end

  assign alu_b = use_imm ? imm_q : rs2_q;

  mc_alu #(.W(XLEN)) u_alu (
    .op_i   (alu_op),
    .a_i    (rs1_q),
    .b_i    (alu_b),
    .y_o    (alu_y),
    .zero_o (zero)
  );

  assign wb_data      = (kind == IK_LOAD) ? mdr_q : res_q;
  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = res_q;
  assign dmem_wdata_o = rs2_q;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_core_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input state_e      state_i,
  input logic [31:0] pc_i,
  input logic        dmem_we_i,
  input logic        rf_we_i
);
  p_fetch_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH) |=> (state_i == ST_DECODE));
  p_exec_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_EXEC) |=> (state_i == ST_MEM));
  p_wb_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WB) |=> (state_i == ST_FETCH));
  p_pc_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH || state_i == ST_DECODE || state_i == ST_MEM)
      |=> $stable(pc_i));
  p_store_in_mem_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_i |-> (state_i == ST_MEM));
  p_store_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_i |=> !dmem_we_i);
  p_regwrite_in_wb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_i |-> (state_i == ST_WB));
endmodule

bind mc_core mc_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .state_i   (state_q),
  .pc_i      (pc_q),
  .dmem_we_i (dmem_we_o),
  .rf_we_i   (rf_we)
);

// File: tb/mc_core_tb_top.sv
`timescale 1ns/1ps
module mc_core_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] imem_addr_o, imem_rdata_i;
  logic [31:0] dmem_addr_o, dmem_wdata_o, dmem_rdata_i;
  logic        dmem_we_o;

  int n_chk = 0;
  int n_err = 0;
  int we_cnt = 0;

  logic [31:0] imem [64];
  logic [31:0] dmem [16];

  always #5 clk_i = ~clk_i;

  mc_core dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .imem_addr_o(imem_addr_o), .imem_rdata_i(imem_rdata_i),
    .dmem_addr_o(dmem_addr_o), .dmem_wdata_o(dmem_wdata_o),
    .dmem_we_o(dmem_we_o), .dmem_rdata_i(dmem_rdata_i)
  );

  assign imem_rdata_i = imem[imem_addr_o[7:2]];
  assign dmem_rdata_i = dmem[dmem_addr_o[5:2]];

  always @(posedge clk_i) if (dmem_we_o) dmem[dmem_addr_o[5:2]] <= dmem_wdata_o;
  always @(negedge clk_i) if (rst_ni && dmem_we_o) we_cnt = we_cnt + 1;

  localparam logic [31:0] NOP = 32'h0000_0013;

  function automatic logic [31:0] enc_r(input logic alt, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd);
    return {1'b0, alt, 5'b0, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
      input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction
  function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
      input logic [4:0] rs1);
    return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(input logic [12:0] imm, input logic [4:0] rs2,
      input logic [4:0] rs1);
    return {imm[12], imm[10:5], rs2, rs1, 3'b000, imm[4:1], imm[11], 7'b1100011};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int k = 0; k < 64; k++) imem[k] = NOP;
    for (int k = 0; k < 16; k++) dmem[k] = 32'h0;
  endtask

  task automatic start();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    we_cnt = 0;
    chk("R1 reset fetch addr", imem_addr_o, 32'h0);
    chk("R1 reset store strobe", {31'b0, dmem_we_o}, 32'h0);
    rst_ni = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  typedef struct packed {
    logic        imm_form;
    logic        alt;
    logic [2:0]  f3;
    logic [11:0] imm;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 3'b000, 12'h000, 32'd5,          32'd7,          32'd12},         // R3 ADD
    '{1'b0, 1'b1, 3'b000, 12'h000, 32'd5,          32'd7,          32'hFFFF_FFFE},  // R3 SUB
    '{1'b0, 1'b0, 3'b111, 12'h000, 32'hF0F0_F0F0,  32'h0FF0_0FF0,  32'h00F0_00F0},  // R3 AND
    '{1'b0, 1'b0, 3'b110, 12'h000, 32'hF0F0_F0F0,  32'h0FF0_0FF0,  32'hFFF0_FFF0},  // R3 OR
    '{1'b0, 1'b0, 3'b100, 12'h000, 32'hF0F0_F0F0,  32'h0FF0_0FF0,  32'hFF00_FF00},  // R3 XOR
    '{1'b0, 1'b0, 3'b010, 12'h000, 32'hFFFF_FFFF,  32'd1,          32'd1},          // R5 SLT signed
    '{1'b0, 1'b0, 3'b010, 12'h000, 32'd1,          32'hFFFF_FFFF,  32'd0},          // R5 SLT signed
    '{1'b0, 1'b0, 3'b001, 12'h000, 32'd1,          32'd31,         32'h8000_0000},  // R3 SLL
    '{1'b0, 1'b0, 3'b001, 12'h000, 32'd3,          32'd33,         32'd6},          // R5 low 5 bits
    '{1'b0, 1'b0, 3'b101, 12'h000, 32'h8000_0000,  32'd4,          32'h0800_0000},  // R3 SRL
    '{1'b0, 1'b1, 3'b101, 12'h000, 32'h8000_0000,  32'd4,          32'hF800_0000},  // R5 SRA
    '{1'b1, 1'b0, 3'b000, 12'hFFD, 32'd10,         32'd0,          32'd7},          // R4 ADDI
    '{1'b1, 1'b0, 3'b111, 12'h0F0, 32'h0000_00FF,  32'd0,          32'h0000_00F0},  // R4 ANDI
    '{1'b1, 1'b0, 3'b110, 12'hFFF, 32'h0000_0100,  32'd0,          32'hFFFF_FFFF},  // R4 ORI
    '{1'b1, 1'b0, 3'b100, 12'h00F, 32'hFFFF_0000,  32'd0,          32'hFFFF_000F},  // R4 XORI
    '{1'b1, 1'b0, 3'b010, 12'hFFE, 32'hFFFF_FFFB,  32'd0,          32'd1},          // R5 SLTI
    '{1'b1, 1'b0, 3'b001, 12'h004, 32'd1,          32'd0,          32'd16},         // R4 SLLI
    '{1'b1, 1'b0, 3'b101, 12'h01F, 32'h8000_0000,  32'd0,          32'd1},          // R4 SRLI
    '{1'b1, 1'b0, 3'b101, 12'h41F, 32'h8000_0000,  32'd0,          32'hFFFF_FFFF}   // R5 SRAI
  };

  initial begin : watchdog
    #(1_500_000);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin : main
    clear_mem();

    // vector table: LW x1; LW x2; op x3; SW x3,8
    for (int i = 0; i < NV; i++) begin
      clear_mem();
      imem[0] = enc_i(12'h0, 5'd0, 3'b010, 5'd1, 7'b0000011);
      imem[1] = enc_i(12'h4, 5'd0, 3'b010, 5'd2, 7'b0000011);
      imem[2] = VECS[i].imm_form ? enc_i(VECS[i].imm, 5'd1, VECS[i].f3, 5'd3, 7'b0010011)
                                 : enc_r(VECS[i].alt, 5'd2, 5'd1, VECS[i].f3, 5'd3);
      imem[3] = enc_s(12'h8, 5'd3, 5'd0);
      dmem[0] = VECS[i].a;
      dmem[1] = VECS[i].b;
      dmem[2] = 32'hDEAD_BEEF;
      start();
      run(20);
      chk($sformatf("R3/R4/R5 vector %0d", i), dmem[2], VECS[i].exp);
    end

    // R6 negative offsets, R2 fetch timing, R9 strobe count
    clear_mem();
    imem[0] = enc_i(12'd16, 5'd0, 3'b000, 5'd1, 7'b0010011); // ADDI x1,x0,16
    imem[1] = enc_s(12'hFFC, 5'd1, 5'd1);                    // SW x1,-4(x1)
    imem[2] = enc_i(12'hFF8, 5'd1, 3'b010, 5'd2, 7'b0000011); // LW x2,-8(x1)
    imem[3] = enc_s(12'h0, 5'd2, 5'd0);                      // SW x2,0(x0)
    dmem[2] = 32'h0000_1234;
    start();
    run(4);  chk("R2 addr held through write-back", imem_addr_o, 32'd0);
    run(1);  chk("R2 addr +4 after write-back", imem_addr_o, 32'd4);
    run(4);  chk("R2 addr held second instr", imem_addr_o, 32'd4);
    run(1);  chk("R2 addr +4 again", imem_addr_o, 32'd8);
    run(10);
    chk("R6 store negative offset", dmem[3], 32'd16);
    chk("R6 load negative offset", dmem[0], 32'h0000_1234);
    chk("R9 one strobe per store", we_cnt, 32'd2);
    run(2);
    // R1 asynchronous reset mid-instruction
    #2 rst_ni = 1'b0;
    #1 chk("R1 async reset clears fetch addr", imem_addr_o, 32'd0);
    chk("R1 async reset clears strobe", {31'b0, dmem_we_o}, 32'd0);

    // R8 x0 stays zero
    clear_mem();
    imem[0] = enc_i(12'd5, 5'd0, 3'b000, 5'd0, 7'b0010011);  // ADDI x0,x0,5
    imem[1] = enc_s(12'h8, 5'd0, 5'd0);                      // SW x0,8
    imem[2] = enc_i(12'h4, 5'd0, 3'b010, 5'd0, 7'b0000011);  // LW x0,4
    imem[3] = enc_s(12'hC, 5'd0, 5'd0);                      // SW x0,12
    dmem[1] = 32'hFFFF_FFFF; dmem[2] = 32'hAAAA_AAAA; dmem[3] = 32'h5555_5555;
    start();
    run(20);
    chk("R8 ALU write to x0 ignored", dmem[2], 32'd0);
    chk("R8 load into x0 ignored", dmem[3], 32'd0);

    // R7 branch taken and not taken
    for (int t = 0; t < 2; t++) begin
      clear_mem();
      imem[0] = enc_i(12'h0, 5'd0, 3'b010, 5'd1, 7'b0000011);
      imem[1] = enc_i(12'h4, 5'd0, 3'b010, 5'd2, 7'b0000011);
      imem[2] = enc_i(12'd7, 5'd0, 3'b000, 5'd3, 7'b0010011);
      imem[3] = enc_b(13'd8, 5'd2, 5'd1);
      imem[4] = enc_i(12'd9, 5'd0, 3'b000, 5'd3, 7'b0010011);
      imem[5] = enc_s(12'h8, 5'd3, 5'd0);
      dmem[0] = 32'h1234_5678;
      dmem[1] = (t == 0) ? 32'h1234_5678 : 32'h1234_5679;
      start();
      run(18);
      chk("R7 fetch addr after execute edge", imem_addr_o, (t == 0) ? 32'd20 : 32'd16);
      run(12);
      chk("R7 branch outcome", dmem[2], (t == 0) ? 32'd7 : 32'd9);
    end

    // R10 unsupported encodings
    clear_mem();
    imem[0] = enc_i(12'h055, 5'd0, 3'b000, 5'd3, 7'b0010011); // ADDI x3,x0,0x55
    imem[1] = 32'h0000_018B;                                  // unknown opcode, rd=3
    imem[2] = enc_r(1'b0, 5'd2, 5'd1, 3'b011, 5'd3);          // funct3 011 register op
    imem[3] = enc_s(12'h8, 5'd3, 5'd0);
    dmem[2] = 32'hDEAD_BEEF;
    start();
    run(15);
    chk("R10 PC steps by 4 over unsupported", imem_addr_o, 32'd12);
    chk("R10 no store from unsupported", we_cnt, 32'd0);
    run(5);
    chk("R10 register untouched", dmem[2], 32'h55);
    chk("R9 single strobe", we_cnt, 32'd1);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule